// File: doc/BRIEF.md
# Register Dependency Tracker with Consumer Wakeup

This block keeps track of register dependencies between in-flight instructions in a scheduling window. For every architectural register it holds the tag of the youngest inserted instruction that will write that register. An instruction enters through the insert port with its tag, up to `NUM_SRC` source registers and an optional destination register. Its sources are looked up in the table, and each live entry makes the new instruction a consumer of the named producer. The instruction then becomes the recorded writer of its destination.

When an instruction finishes, it arrives on the completion port. The block removes that producer from the wait set of every consumer and retires its table entry, but only if no younger writer has replaced it. A consumer whose wait set becomes empty is flagged ready. An instruction inserted with no live producer is flagged ready straight away. Flagged instructions are held in a pending set and emitted one per cycle on a registered ready output, lowest tag first, so wakeups that arrive together are not lost.

The surrounding scheduler owns tag allocation. It inserts only free tags, and it completes only tags that have already been emitted as ready.

Top module: `dep_wakeup`

## Requirements
- R1: Only the youngest writer of a register is remembered. A consumer inserted after two writers of the same register waits on the second writer only, and completing the first writer does not release it.
- R2: An inserted instruction whose source names a register with a live writer waits on that writer. Two sources naming the same producer create one dependence. A source is used only when its bit in `ins_src_vld` is set, and source s is `ins_src[s*REG_W +: REG_W]`.
- R3: Source lookup sees the table as it was before the inserting instruction records itself. An instruction that reads and writes the same register waits on the previous writer, never on itself.
- R4: An inserted instruction with no live producer is emitted on the ready output two clock edges after the insert edge.
- R5: A completion clears its destination entry only while that entry still holds the completing tag. When a younger writer has replaced the entry, the entry stays in place.
- R6: A completion removes its producer from every consumer's wait set. A consumer left with no producer is emitted as ready, at the earliest two edges after the completion edge.
- R7: When an insertion writes the register whose entry a same-cycle completion would clear, the insertion wins. The entry then names the inserted tag.
- R8: At most one tag is emitted per cycle (`rdy_valid` high, tag on `rdy_tag`). Pending tags are emitted lowest tag first, and every flagged tag is emitted exactly once.
- R9: A source whose table entry names the tag completing in the same cycle creates no dependence.
- R10: While `rst` is high and on the first cycle after it, `rdy_valid` is low, and the table and all wait sets are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_tag | input | TAG_W | Tag of the inserted instruction |
| ins_src_vld | input | NUM_SRC | Per-source valid bits |
| ins_src | input | NUM_SRC*REG_W | Source registers, source s at bits s*REG_W and up |
| ins_dst_vld | input | 1 | Inserted instruction writes a register |
| ins_dst | input | REG_W | Destination register |
| cmp_valid | input | 1 | An instruction completes this cycle |
| cmp_tag | input | TAG_W | Tag of the completing instruction |
| rdy_valid | output | 1 | A ready tag is presented this cycle |
| rdy_tag | output | TAG_W | The ready tag |

## Verification
An insertion and a completion can fall in the same cycle, and they then contend for the same table entry or the same producer link. The bench provokes this on purpose in two ways. It inserts a writer of the register that the completing producer owns, which must leave the new writer in the table. It also inserts a consumer of the completing producer, which must become ready at once rather than wait forever. Random traffic mixes both ports on most cycles. Every cycle's ready output is judged against a bench model built from the requirements, and later consumers of the contested register show whether the entry survived.

// File: rtl/dw_pkg.sv
package dw_pkg;

  // Index of the lowest set bit of a vector of up to 64 bits; 0 when empty.
  function automatic int unsigned first_one(input logic [63:0] v);
    first_one = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) first_one = i;
    end
  endfunction

endpackage

// File: rtl/dw_table.sv
module dw_table #(
  parameter int NUM_REGS = 16,
  parameter int NUM_TAGS = 8,
  parameter int NUM_SRC  = 2,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ins_valid,
  input  logic [TAG_W-1:0]         ins_tag,
  input  logic [NUM_SRC-1:0]       ins_src_vld,
  input  logic [NUM_SRC*REG_W-1:0] ins_src,
  input  logic                     ins_dst_vld,
  input  logic [REG_W-1:0]         ins_dst,
  input  logic                     cmp_valid,
  input  logic [TAG_W-1:0]         cmp_tag,
  output logic [NUM_SRC-1:0]       src_hit,
  output logic [NUM_SRC*TAG_W-1:0] src_prod
);

  // Youngest writer per register.
  logic [NUM_REGS-1:0] wr_vld;
  logic [TAG_W-1:0]    wr_tag [NUM_REGS];
  // Destination remembered per tag, used when that tag completes.
  logic [REG_W-1:0]    tag_dst [NUM_TAGS];
  logic [NUM_TAGS-1:0] tag_dv;

  logic [REG_W-1:0] cmp_reg;
  logic             cmp_has_dst;
  logic             ins_writes;
  logic             ins_hits_cmp_reg;
  logic             clear_en;

  // Lookup reads the table before this cycle's update.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [REG_W-1:0] sreg;
    assign sreg = ins_src[s*REG_W +: REG_W];
    assign src_hit[s] = ins_src_vld[s] && wr_vld[sreg] &&
                        !(cmp_valid && (wr_tag[sreg] == cmp_tag));
    assign src_prod[s*TAG_W +: TAG_W] = wr_tag[sreg];
  end

  assign cmp_reg          = tag_dst[cmp_tag];
  assign cmp_has_dst      = tag_dv[cmp_tag];
  assign ins_writes       = ins_valid && ins_dst_vld;
  assign ins_hits_cmp_reg = ins_writes && (ins_dst == cmp_reg);
  assign clear_en         = cmp_valid && cmp_has_dst && wr_vld[cmp_reg] &&
                            (wr_tag[cmp_reg] == cmp_tag) && !ins_hits_cmp_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_vld <= '0;
      tag_dv <= '0;
      for (int r = 0; r < NUM_REGS; r++) wr_tag[r] <= '0;
      for (int t = 0; t < NUM_TAGS; t++) tag_dst[t] <= '0;
    end else begin
      if (clear_en) wr_vld[cmp_reg] <= 1'b0;
      if (ins_writes) begin
        wr_vld[ins_dst] <= 1'b1;
        wr_tag[ins_dst] <= ins_tag;
      end
      if (ins_valid) begin
        tag_dst[ins_tag] <= ins_dst;
        tag_dv[ins_tag]  <= ins_dst_vld;
      end
    end
  end

  // R7: a same-cycle insert to the completing writer's register keeps the entry.
  p_insert_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_has_dst && ins_hits_cmp_reg) |=>
      (wr_vld[$past(ins_dst)] && (wr_tag[$past(ins_dst)] == $past(ins_tag))));

  // R5: a completion whose entry was overtaken leaves that entry untouched.
  p_keep_younger_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_has_dst && wr_vld[cmp_reg] &&
     (wr_tag[cmp_reg] != cmp_tag) && !ins_writes) |=>
      (wr_vld[$past(cmp_reg)] && (wr_tag[$past(cmp_reg)] == $past(wr_tag[cmp_reg]))));

endmodule

// File: rtl/dw_wait.sv
module dw_wait #(
  parameter int NUM_TAGS = 8,
  parameter int NUM_SRC  = 2,
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ins_valid,
  input  logic [TAG_W-1:0]         ins_tag,
  input  logic [NUM_SRC-1:0]       src_hit,
  input  logic [NUM_SRC*TAG_W-1:0] src_prod,
  input  logic                     cmp_valid,
  input  logic [TAG_W-1:0]         cmp_tag,
  output logic [NUM_TAGS-1:0]      new_rdy,
  output logic [NUM_TAGS-1:0]      blocked
);

  // Row c holds the producers consumer c waits on; column p is p's dependent list.
  logic [NUM_TAGS-1:0] wait_q [NUM_TAGS];
  logic [NUM_TAGS-1:0] wait_d [NUM_TAGS];
  logic [NUM_TAGS-1:0] prod_mask;
  logic [NUM_TAGS-1:0] col_clr;

  always_comb begin
    prod_mask = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_hit[s]) prod_mask[src_prod[s*TAG_W +: TAG_W]] = 1'b1;
    end
  end

  assign col_clr = cmp_valid ? (NUM_TAGS'(1) << cmp_tag) : '0;

  always_comb begin
    for (int c = 0; c < NUM_TAGS; c++) begin
      if (ins_valid && (ins_tag == TAG_W'(c))) begin
        wait_d[c]  = prod_mask;
        new_rdy[c] = (prod_mask == '0);
      end else begin
        wait_d[c]  = wait_q[c] & ~col_clr;
        new_rdy[c] = (wait_q[c] != '0) && (wait_d[c] == '0);
      end
      blocked[c] = (wait_q[c] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_TAGS; c++) wait_q[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_TAGS; c++) wait_q[c] <= wait_d[c];
    end
  end

  for (genvar c = 0; c < NUM_TAGS; c++) begin : g_chk
    // R6: after a completion no consumer still waits on that producer.
    p_link_gone_r6: assert property (@(posedge clk) disable iff (rst)
      cmp_valid |=> !wait_q[c][$past(cmp_tag)]);
  end

endmodule

// File: rtl/dw_pick.sv
module dw_pick #(
  parameter int NUM_TAGS = 8,
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAGS-1:0] new_rdy,
  output logic                rdy_valid,
  output logic [TAG_W-1:0]    rdy_tag
);

  logic [NUM_TAGS-1:0] pend_q;
  logic [NUM_TAGS-1:0] grant;
  logic [TAG_W-1:0]    pick_idx;
  logic                any_pend;

  assign any_pend = (pend_q != '0);
  assign pick_idx = TAG_W'(dw_pkg::first_one(64'(pend_q)));
  assign grant    = any_pend ? (NUM_TAGS'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      rdy_valid <= 1'b0;
      rdy_tag   <= '0;
    end else begin
      pend_q    <= (pend_q & ~grant) | new_rdy;
      rdy_valid <= any_pend;
      rdy_tag   <= pick_idx;
    end
  end

  // R8: a tag is never flagged again while it is still pending.
  p_no_dup_r8: assert property (@(posedge clk) disable iff (rst)
    (new_rdy & pend_q) == '0);

endmodule

// File: rtl/dep_wakeup.sv
module dep_wakeup #(
  parameter int NUM_REGS = 16,
  parameter int NUM_TAGS = 8,
  parameter int NUM_SRC  = 2,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ins_valid,
  input  logic [TAG_W-1:0]         ins_tag,
  input  logic [NUM_SRC-1:0]       ins_src_vld,
  input  logic [NUM_SRC*REG_W-1:0] ins_src,
  input  logic                     ins_dst_vld,
  input  logic [REG_W-1:0]         ins_dst,
  input  logic                     cmp_valid,
  input  logic [TAG_W-1:0]         cmp_tag,
  output logic                     rdy_valid,
  output logic [TAG_W-1:0]         rdy_tag
);

  logic [NUM_SRC-1:0]       src_hit;
  logic [NUM_SRC*TAG_W-1:0] src_prod;
  logic [NUM_TAGS-1:0]      new_rdy;
  logic [NUM_TAGS-1:0]      blocked;

  dw_table #(.NUM_REGS(NUM_REGS), .NUM_TAGS(NUM_TAGS), .NUM_SRC(NUM_SRC)) u_table (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_tag(ins_tag),
    .ins_src_vld(ins_src_vld), .ins_src(ins_src),
    .ins_dst_vld(ins_dst_vld), .ins_dst(ins_dst),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .src_hit(src_hit), .src_prod(src_prod)
  );

  dw_wait #(.NUM_TAGS(NUM_TAGS), .NUM_SRC(NUM_SRC)) u_wait (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_tag(ins_tag),
    .src_hit(src_hit), .src_prod(src_prod),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .new_rdy(new_rdy), .blocked(blocked)
  );

  dw_pick #(.NUM_TAGS(NUM_TAGS)) u_pick (
    .clk(clk), .rst(rst),
    .new_rdy(new_rdy),
    .rdy_valid(rdy_valid), .rdy_tag(rdy_tag)
  );

  // R4: an emitted tag waits on no producer.
  p_emit_unblocked_r4: assert property (@(posedge clk) disable iff (rst)
    rdy_valid |-> !blocked[rdy_tag]);

endmodule

// File: tb/dep_wakeup_tb.sv
module dep_wakeup_tb;

  localparam int NR = 16;
  localparam int NT = 8;
  localparam int RW = 4;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ins_valid = 1'b0;
  logic [TW-1:0] ins_tag = '0;
  logic [1:0]    ins_src_vld = '0;
  logic [2*RW-1:0] ins_src = '0;
  logic          ins_dst_vld = 1'b0;
  logic [RW-1:0] ins_dst = '0;
  logic          cmp_valid = 1'b0;
  logic [TW-1:0] cmp_tag = '0;
  logic          rdy_valid;
  logic [TW-1:0] rdy_tag;

  always #10 clk = ~clk;

  dep_wakeup #(.NUM_REGS(NR), .NUM_TAGS(NT), .NUM_SRC(2)) u_dut (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_tag(ins_tag),
    .ins_src_vld(ins_src_vld), .ins_src(ins_src),
    .ins_dst_vld(ins_dst_vld), .ins_dst(ins_dst),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .rdy_valid(rdy_valid), .rdy_tag(rdy_tag)
  );

  int n_chk = 0;
  int n_bad = 0;
  string lbl = "R10";

  // Reference model state.
  bit          m_wv [NR];
  int          m_wt [NR];
  int          m_dst [NT];
  bit          m_dv [NT];
  bit [NT-1:0] m_wait [NT];
  bit [NT-1:0] m_pend;
  bit          exp_rv;
  int          exp_rt;
  // Legal-traffic bookkeeping.
  bit          inflight [NT];
  bit          emitted [NT];

  function automatic int lowest(input bit [NT-1:0] v);
    for (int i = 0; i < NT; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin m_wv[r] = 0; m_wt[r] = 0; end
    for (int t = 0; t < NT; t++) begin
      m_dst[t] = 0; m_dv[t] = 0; m_wait[t] = '0; inflight[t] = 0; emitted[t] = 0;
    end
    m_pend = '0;
    exp_rv = 0;
    exp_rt = 0;
  endtask

  task automatic model_step(input bit iv, input int it, input bit s0v, input int s0,
                            input bit s1v, input int s1, input bit dv, input int d,
                            input bit cv, input int ct);
    bit [NT-1:0] np, nr, pm, row;
    bit [NT-1:0] nw [NT];
    int cd;
    exp_rv = (m_pend != '0);
    exp_rt = lowest(m_pend);
    np = m_pend;
    if (exp_rv) np[exp_rt] = 1'b0;
    pm = '0;
    if (s0v && m_wv[s0] && !(cv && m_wt[s0] == ct)) pm[m_wt[s0]] = 1'b1;
    if (s1v && m_wv[s1] && !(cv && m_wt[s1] == ct)) pm[m_wt[s1]] = 1'b1;
    nr = '0;
    for (int i = 0; i < NT; i++) begin
      row = m_wait[i];
      if (cv) row[ct] = 1'b0;
      if (iv && it == i) begin
        nw[i] = pm; nr[i] = (pm == '0);
      end else begin
        nw[i] = row; nr[i] = (m_wait[i] != '0) && (row == '0);
      end
    end
    cd = m_dst[ct];
    if (cv && m_dv[ct] && m_wv[cd] && m_wt[cd] == ct && !(iv && dv && d == cd)) m_wv[cd] = 0;
    if (iv && dv) begin m_wv[d] = 1; m_wt[d] = it; end
    if (iv) begin m_dst[it] = d; m_dv[it] = dv; end
    for (int i = 0; i < NT; i++) m_wait[i] = nw[i];
    m_pend = np | nr;
  endtask

  task automatic check_out();
    n_chk++;
    if (rdy_valid !== exp_rv || (exp_rv && rdy_tag !== TW'(exp_rt))) begin
      n_bad++;
      $display("FAIL %s: rdy_valid/rdy_tag actual %0b/%0d expected %0b/%0d",
               lbl, rdy_valid, rdy_tag, exp_rv, exp_rt);
    end
    if (exp_rv) emitted[exp_rt] = 1;
  endtask

  // One clock cycle: drive at the falling edge, check after the rising edge.
  task automatic cyc(input bit iv, input int it, input bit s0v, input int s0,
                     input bit s1v, input int s1, input bit dv, input int d,
                     input bit cv, input int ct);
    ins_valid   = iv;
    ins_tag     = TW'(it);
    ins_src_vld = {s1v, s0v};
    ins_src     = {RW'(s1), RW'(s0)};
    ins_dst_vld = dv;
    ins_dst     = RW'(d);
    cmp_valid   = cv;
    cmp_tag     = TW'(ct);
    model_step(iv, it, s0v, s0, s1v, s1, dv, d, cv, ct);
    if (iv) begin inflight[it] = 1; emitted[it] = 0; end
    if (cv) inflight[ct] = 0;
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    int seed;
    int it, ct, off;
    bit iv, cv;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    lbl = "R10";
    n_chk++;
    if (rdy_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: rdy_valid in reset actual %0b expected 0", rdy_valid);
    end
    rst = 1'b0;
    idle(2);

    lbl = "R4";  cyc(1, 0, 0, 0, 0, 0, 1, 1, 0, 0); idle(2);
    lbl = "R2";  cyc(1, 1, 1, 1, 0, 0, 1, 2, 0, 0); idle(2);
    lbl = "R6";  cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); idle(3);
    lbl = "R3";  cyc(1, 2, 0, 0, 0, 0, 1, 4, 0, 0); idle(2);
    cyc(1, 3, 1, 4, 1, 4, 1, 4, 1, 1); idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 2); idle(3);
    lbl = "R1";  cyc(1, 4, 0, 0, 0, 0, 1, 5, 0, 0);
    cyc(1, 5, 0, 0, 0, 0, 1, 5, 0, 0); idle(3);
    cyc(1, 6, 1, 5, 0, 0, 0, 0, 1, 3);
    lbl = "R5";  cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 4); idle(2);
    cyc(1, 7, 1, 5, 0, 0, 0, 0, 0, 0); idle(1);
    lbl = "R8";  cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 5); idle(4);
    lbl = "R7";  cyc(1, 0, 0, 0, 0, 0, 1, 7, 0, 0); idle(2);
    cyc(1, 1, 0, 0, 0, 0, 1, 7, 1, 0); idle(2);
    cyc(1, 2, 1, 7, 0, 0, 0, 0, 0, 0); idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1); idle(3);
    lbl = "R9";  cyc(1, 4, 0, 0, 0, 0, 1, 8, 0, 0); idle(2);
    cyc(1, 5, 1, 8, 0, 0, 0, 0, 1, 4); idle(3);

    lbl = "R8";
    for (int n = 0; n < 4000; n++) begin
      iv = ($urandom_range(99) < 60);
      cv = ($urandom_range(99) < 50);
      it = -1; ct = -1;
      off = $urandom_range(NT - 1);
      for (int k = 0; k < NT; k++) begin
        int t;
        t = (off + k) % NT;
        if (iv && it < 0 && !inflight[t]) it = t;
      end
      off = $urandom_range(NT - 1);
      for (int k = 0; k < NT; k++) begin
        int t;
        t = (off + k) % NT;
        if (cv && ct < 0 && inflight[t] && emitted[t] && t != it) ct = t;
      end
      cyc(it >= 0, (it >= 0) ? it : 0,
          $urandom_range(1), $urandom_range(NR - 1),
          $urandom_range(1), $urandom_range(NR - 1),
          $urandom_range(3) != 0, $urandom_range(NR - 1),
          ct >= 0, (ct >= 0) ? ct : 0);
    end
    idle(10);
    summary();
    $finish;
  end

endmodule